// File: doc/BRIEF.md
# Checksum-Verified Microcode Patch Loader

This engine runs once at boot under a fixed, hard-coded sequence. A start pulse makes it read a patch image from a permanent-storage port, one word per request/valid handshake. The image begins with a two-word header and is followed by the payload. Each payload word goes into the writable control store. A running 32-bit checksum of those words is updated in the same cycle as the write.

After the last payload word, the loader compares its sum with the checksum carried in the header. If the two match exactly, it raises a level output that hands execution to the patched store. If they differ, it writes zero to every store location, one address per cycle, and then raises a fail level. That fail level means the processor keeps running its built-in microcode. A header that claims more words than the store can hold takes the same clearing path, and no payload is fetched.

Top module: `ucode_patch_loader`

## Requirements
- R1: After reset, `activate`, `fail`, `src_req` and `cs_we` are low. The loader stays idle, issuing no read and no write, until `start` is pulsed.
- R2: Source address 0 holds the payload word count N and source address 1 holds the expected checksum. Payload words at source addresses 2 to N+1 are written in order to store addresses 0 to N-1. Store locations at N and above are not written on success.
- R3: At most one read is outstanding. `src_addr` stays stable while `src_req` is high and `src_valid` is low. Each store write of payload happens in the cycle its `src_valid` arrives. The next request follows that write, and addresses rise by one from 0.
- R4: The checksum is the sum of the N payload words modulo 2^32 (header words excluded), with wrap-around on overflow.
- R5: On an exact match, `activate` rises and stays high until reset, and `fail` stays low. `activate` and `fail` are never high together.
- R6: On any mismatch, even a single bit, the loader writes zero to store addresses 0 to DEPTH-1, one per cycle. It then raises `fail` and holds it until reset. `activate` stays low.
- R7: A word count greater than DEPTH reads no payload word (only the two header reads occur) and takes the clearing path of R6.
- R8: A word count of zero performs no store write and compares a sum of zero with the expected checksum.
- R9: `start` has no effect while a load is in progress or after it has finished: no new read sequence begins and the outcome is unchanged.
- R10: The store write strobe is active only while copying payload or clearing, and never after the outcome is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins the load |
| src_req | output | 1 | Read request to permanent storage, held until `src_valid` |
| src_addr | output | SRC_AW | Word address of the current read |
| src_valid | input | 1 | Read data valid, one cycle per request |
| src_data | input | 32 | Read data word |
| cs_we | output | 1 | Control store write strobe |
| cs_addr | output | clog2(DEPTH) | Control store write address |
| cs_wdata | output | 32 | Control store write data |
| activate | output | 1 | Patched microcode enabled (level) |
| fail | output | 1 | Patch rejected, built-in microcode retained (level) |

## Verification
Several rules are checked every cycle by the assertions:
- the stable read address while a request waits,
- payload writes only on a valid beat,
- zero data and no source requests during clearing,
- the hold and mutual exclusion of the two outcome levels,
- the absence of writes once the outcome is signalled.

Other behaviour can only be shown by the bench's scenarios. These are the actual checksum arithmetic with wrap-around, the exact payload placement and untouched upper locations, the full sweep of the clear, the single-bit mismatch, the oversized and empty headers, and the ignored restart.

// File: rtl/ucode_loader_pkg.sv
package ucode_loader_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_HDR,
        ST_COPY,
        ST_COMPARE,
        ST_ACTIVATE,
        ST_CLEAR,
        ST_DONE
    } ldr_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] n_words;
        logic [WORD_W-1:0] exp_sum;
    } patch_hdr_t;

    function automatic logic [WORD_W-1:0] csum_step(input logic [WORD_W-1:0] acc,
                                                    input logic [WORD_W-1:0] word);
        return acc + word;
    endfunction

endpackage

// File: rtl/ucode_csum_acc.sv
module ucode_csum_acc
    import ucode_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sum
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= csum_step(sum, word);
        end
    end
endmodule

// File: rtl/ucode_clear_seq.sv
module ucode_clear_seq #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    assign last = (addr == TOP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            addr <= '0;
        end else if (!last) begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/ucode_store_port.sv
module ucode_store_port #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          copy_en,
    input  logic [AW-1:0] copy_addr,
    input  logic [DW-1:0] copy_data,
    input  logic          wipe_en,
    input  logic [AW-1:0] wipe_addr,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    always_comb begin
        we    = copy_en | wipe_en;
        addr  = wipe_en ? wipe_addr : copy_addr;
        wdata = wipe_en ? '0 : copy_data;
    end
endmodule

// File: rtl/ucode_patch_loader.sv
module ucode_patch_loader
    import ucode_loader_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int SRC_AW = 12,
    localparam int CS_AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              src_req,
    output logic [SRC_AW-1:0] src_addr,
    input  logic              src_valid,
    input  logic [WORD_W-1:0] src_data,
    output logic              cs_we,
    output logic [CS_AW-1:0]  cs_addr,
    output logic [WORD_W-1:0] cs_wdata,
    output logic              activate,
    output logic              fail
);
    localparam logic [WORD_W-1:0] DEPTH_W = WORD_W'(DEPTH);

    ldr_state_e        state;
    patch_hdr_t        hdr;
    logic [SRC_AW-1:0] rd_ptr;
    logic [CS_AW:0]    wr_ptr;
    logic              req_q, act_q, fail_q;
    logic              rd_fire, copy_fire, copy_last, csum_ok;
    logic [WORD_W-1:0] csum;
    logic [CS_AW-1:0]  clr_addr;
    logic              clr_last, clr_run;

    assign rd_fire   = req_q && src_valid;
    assign copy_fire = (state == ST_COPY) && rd_fire;
    assign copy_last = (WORD_W'(wr_ptr) == hdr.n_words - WORD_W'(1));
    assign csum_ok   = (csum == hdr.exp_sum);
    assign clr_run   = (state == ST_CLEAR);

    assign src_req  = req_q;
    assign src_addr = rd_ptr;
    assign activate = act_q;
    assign fail     = fail_q;

    ucode_csum_acc u_csum (
        .clk    (clk),
        .rst    (rst),
        .clr    (state == ST_IDLE),
        .add_en (copy_fire),
        .word   (src_data),
        .sum    (csum)
    );

    ucode_clear_seq #(.DEPTH(DEPTH), .AW(CS_AW)) u_clear (
        .clk  (clk),
        .rst  (rst),
        .run  (clr_run),
        .addr (clr_addr),
        .last (clr_last)
    );

    ucode_store_port #(.AW(CS_AW), .DW(WORD_W)) u_port (
        .copy_en   (copy_fire),
        .copy_addr (wr_ptr[CS_AW-1:0]),
        .copy_data (src_data),
        .wipe_en   (clr_run),
        .wipe_addr (clr_addr),
        .we        (cs_we),
        .addr      (cs_addr),
        .wdata     (cs_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hdr    <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            req_q  <= 1'b0;
            act_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_READ_HDR;
                        rd_ptr <= '0;
                        wr_ptr <= '0;
                        req_q  <= 1'b1;
                    end
                end
                ST_READ_HDR: begin
                    if (rd_fire) begin
                        rd_ptr <= rd_ptr + SRC_AW'(1);
                        if (rd_ptr == '0) begin
                            hdr.n_words <= src_data;
                        end else begin
                            hdr.exp_sum <= src_data;
                            if (hdr.n_words == '0) begin
                                req_q <= 1'b0;
                                state <= ST_COMPARE;
                            end else if (hdr.n_words > DEPTH_W) begin
                                req_q <= 1'b0;
                                state <= ST_CLEAR;
                            end else begin
                                state <= ST_COPY;
                            end
                        end
                    end
                end
                ST_COPY: begin
                    if (rd_fire) begin
                        rd_ptr <= rd_ptr + SRC_AW'(1);
                        wr_ptr <= wr_ptr + (CS_AW+1)'(1);
                        if (copy_last) begin
                            req_q <= 1'b0;
                            state <= ST_COMPARE;
                        end
                    end
                end
                ST_COMPARE:  state <= csum_ok ? ST_ACTIVATE : ST_CLEAR;
                ST_ACTIVATE: begin
                    act_q <= 1'b1;
                    state <= ST_DONE;
                end
                ST_CLEAR: begin
                    if (clr_last) begin
                        fail_q <= 1'b1;
                        state  <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr))); // R3
    AST_COPY_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
        (cs_we && state == ST_COPY) |-> (src_valid && src_req)); // R3
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        activate |=> activate); // R5
    AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(activate && fail)); // R5
    AST_MISMATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMPARE && csum != hdr.exp_sum) |=> (state == ST_CLEAR && !activate)); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLEAR) |-> (cs_we && cs_wdata == '0 && !src_req)); // R6
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && !activate)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!src_req && !cs_we)); // R1
    AST_NO_LATE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (activate || fail) |-> (!cs_we && !src_req)); // R10
endmodule

// File: tb/ucode_patch_loader_test.sv
`timescale 1ns/1ps
module ucode_patch_loader_test;
    localparam int DEPTH  = 16;
    localparam int SRC_AW = 12;
    localparam int AW     = $clog2(DEPTH);

    typedef struct packed {
        logic [31:0] cnt;
        logic [31:0] flip;
        logic [7:0]  lat;
        logic [7:0]  seed;
        logic        restart;
    } vec_t;

    // count, checksum corruption mask, source latency, payload seed, restart pulse
    localparam vec_t VECS [7] = '{
        '{32'd5,  32'h0,          8'd0, 8'h11, 1'b0},  // R2 R5 basic pass
        '{32'd16, 32'h0,          8'd2, 8'h22, 1'b1},  // R2 R9 full depth with restart
        '{32'd7,  32'h0000_0001,  8'd1, 8'h33, 1'b0},  // R6 single-bit mismatch
        '{32'd3,  32'h8000_0000,  8'd3, 8'h44, 1'b0},  // R6 top-bit mismatch
        '{32'd0,  32'h0,          8'd1, 8'h55, 1'b0},  // R8 empty payload
        '{32'd17, 32'h0,          8'd0, 8'h66, 1'b0},  // R7 oversize count
        '{32'd9,  32'h0,          8'd1, 8'hF7, 1'b0}   // R4 wrap-around sum
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              src_req;
    logic [SRC_AW-1:0] src_addr;
    logic              src_valid;
    logic [31:0]       src_data;
    logic              cs_we;
    logic [AW-1:0]     cs_addr;
    logic [31:0]       cs_wdata;
    logic              activate;
    logic              fail;

    int checks = 0;
    int errors = 0;

    logic [31:0] payload [32];
    logic [31:0] hdr_cnt, hdr_sum;
    int          lat = 0;
    logic        prefill = 1'b0;

    logic [31:0] store [DEPTH];
    int          wr_count;
    int          rd_count;
    int          seq_err;

    always #2.5 clk = ~clk;

    ucode_patch_loader #(.DEPTH(DEPTH), .SRC_AW(SRC_AW)) uut (
        .clk(clk), .rst(rst), .start(start),
        .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
        .cs_we(cs_we), .cs_addr(cs_addr), .cs_wdata(cs_wdata),
        .activate(activate), .fail(fail)
    );

    function automatic logic [31:0] fill_pat(input int i);
        return 32'hDEAD_0000 | 32'(i);
    endfunction

    function automatic logic [31:0] src_word(input logic [SRC_AW-1:0] a);
        if (a == 0) return hdr_cnt;
        if (a == 1) return hdr_sum;
        if (int'(a) - 2 < 32) return payload[int'(a) - 2];
        return 32'h0;
    endfunction

    // control store model
    always @(posedge clk) begin
        if (prefill) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= fill_pat(i);
            wr_count <= 0;
        end else if (cs_we) begin
            store[cs_addr] <= cs_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // permanent storage model with request/valid handshake
    initial begin
        int wait_cnt;
        logic [SRC_AW-1:0] next_addr;
        src_valid = 1'b0;
        src_data  = '0;
        wait_cnt  = 0;
        next_addr = '0;
        rd_count  = 0;
        seq_err   = 0;
        forever begin
            @(negedge clk);
            src_valid = 1'b0;
            if (rst) begin
                wait_cnt  = 0;
                next_addr = '0;
                rd_count  = 0;
                seq_err   = 0;
            end else if (src_req) begin
                if (wait_cnt >= lat) begin
                    if (src_addr != next_addr) seq_err++;
                    next_addr = src_addr + SRC_AW'(1);
                    src_valid = 1'b1;
                    src_data  = src_word(src_addr);
                    rd_count++;
                    wait_cnt  = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        prefill = 1'b1;
        repeat (2) @(negedge clk);
        prefill = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] sum;
        logic        pass;
        int          n, exp_wr, exp_rd, guard;
        sum = '0;
        for (int i = 0; i < 32; i++) begin
            payload[i] = ((32'(i) + 32'd1) * 32'h9E37_79B9) ^ {v.seed, 24'h0} ^ 32'(v.seed);
            if (i < int'(v.cnt) && i < DEPTH) sum = sum + payload[i];
        end
        hdr_cnt = v.cnt;
        hdr_sum = sum ^ v.flip;
        lat = int'(v.lat);
        do_reset();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (v.restart) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (!activate && !fail && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 3000, "R5 R6 watchdog", 32'(guard), 32'd3000);
        repeat (3) @(negedge clk);
        n    = int'(v.cnt);
        pass = (v.flip == 0) && (n <= DEPTH);
        exp_wr = (n > DEPTH) ? DEPTH : (pass ? n : n + DEPTH);
        exp_rd = (n > DEPTH) ? 2 : n + 2;
        chk(activate == pass, pass ? "R5 activate" : "R6 activate low", 32'(activate), 32'(pass));
        chk(fail == !pass, pass ? "R5 fail low" : "R6 R7 fail", 32'(fail), 32'(!pass));
        chk(wr_count == exp_wr, "R10 R8 write count", 32'(wr_count), 32'(exp_wr));
        chk(rd_count == exp_rd, "R7 R9 read count", 32'(rd_count), 32'(exp_rd));
        chk(seq_err == 0, "R3 address order", 32'(seq_err), 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            logic [31:0] e;
            if (!pass)      e = 32'h0;
            else if (i < n) e = payload[i];
            else            e = fill_pat(i);
            chk(store[i] == e, pass ? "R2 R4 store word" : "R6 cleared word", store[i], e);
        end
    endtask

    initial begin
        // R1: reset state and idle without start
        do_reset();
        chk(!activate && !fail, "R1 outcome low", {30'h0, activate, fail}, 32'h0);
        repeat (10) begin
            @(negedge clk);
            chk(!src_req && !cs_we, "R1 idle quiet", {30'h0, src_req, cs_we}, 32'h0);
        end
        chk(rd_count == 0 && wr_count == 0, "R1 no traffic", 32'(rd_count + wr_count), 32'h0);

        for (int v = 0; v < 7; v++) run_vec(VECS[v]);

        // R9: start after the outcome is signalled
        begin
            int rd_before;
            rd_before = rd_count;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (20) begin
                @(negedge clk);
                chk(!src_req, "R9 no request after done", 32'(src_req), 32'h0);
            end
            chk(rd_count == rd_before, "R9 read count frozen", 32'(rd_count), 32'(rd_before));
            chk(activate == 1'b1, "R9 R5 activate held", 32'(activate), 32'h1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule